// File: doc/BRIEF.md
# RTC Alarm Interrupt and Frequency-Output Controller

This block sits behind a real-time clock's time comparator. For each of two alarms it takes a one-cycle match strobe and keeps a sticky status flag that software clears by reading the status register. Every flag latches on a match whether or not that alarm's interrupt is enabled. Enabled matches drive a single active-low output pin low for a fixed 20 ms, measured as 655 rising edges of the 32.768 kHz reference.

A mode bit picks the interrupt style. In single-event mode an alarm disarms itself after it fires. It re-arms when software rewrites its enable bit or the mode bit to a new value. In recurring mode every match fires a fresh pulse.

The same pin can instead carry one of three reference clocks, chosen by a two-bit select code. While a clock is selected, the alarm interrupt does not reach the pin. A new select code is adopted only on a rising edge of the 32.768 kHz reference, so a code change cannot cut a pulse short.

Top module: `rtc_alarm_irq`

## Requirements
- R1: A match on an alarm whose enable bit is 0 never starts an interrupt pulse; with select code 00 and no pulse running, the pin stays high.
- R2: A match strobe on alarm i sets flags_o[i] from the next clock on, whatever the value of its enable bit.
- R3: A status-read strobe clears both flags on the next clock. If a match on alarm i arrives in the same cycle, flags_o[i] is set instead.
- R4: An enabled, armed match while active code 00 is in force drives the pin low from the next clock. The pin returns high once 655 rising edges of the 32.768 kHz reference have been counted. A rising edge is that reference sampled high after it was low on the previous clock.
- R5: An enabled, armed match that arrives while a pulse is running restarts the full 655-edge count. It does not queue a second pulse.
- R6: With the mode bit 0, an alarm that fires is disarmed, and its later matches set only the flag. It re-arms in any cycle where its enable bit or the mode bit differs from the value it had on the previous clock.
- R7: With the mode bit 1, an armed alarm stays armed after firing, so every enabled match starts a pulse.
- R8: Select code 00 routes the interrupt to the pin. Code 01 passes the 32.768 kHz reference level, code 10 the 100 Hz level and code 11 the 1 Hz level, each combinationally while that code is active.
- R9: The active select code changes to the requested one only at the clock where a rising edge of the 32.768 kHz reference is detected.
- R10: While the active code is nonzero, matches set their flags but neither start a pulse nor disarm an alarm.
- R11: After reset the flags are 0, the pin is high, both alarms are armed, and the active code is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| match_i | input | 2 | One-cycle alarm match strobes from the time comparator |
| alarm_en_i | input | 2 | Per-alarm interrupt enable bits |
| pulse_mode_i | input | 1 | 0 = single event, 1 = recurring pulse |
| fsel_i | input | 2 | Requested pin function: 00 interrupt, 01 32.768 kHz, 10 100 Hz, 11 1 Hz |
| stat_rd_i | input | 1 | Strobe marking completion of a status-register read |
| ref_hf_i | input | 1 | 32.768 kHz reference level, synchronous to clk |
| ref_centi_i | input | 1 | 100 Hz reference level, synchronous to clk |
| ref_sec_i | input | 1 | 1 Hz reference level, synchronous to clk |
| flags_o | output | 2 | Sticky alarm status flags |
| pin_o | output | 1 | Shared output: active-low interrupt or selected reference |

## Verification
Directed passes come first:
- a disabled match, which separates flag latching from pulse generation;
- a read that coincides with a match, which shows whether set beats clear;
- repeated matches in each mode, which separate self-disarming from recurring behaviour;
- a second match in mid-pulse, which shows whether the count restarts or a second pulse is stacked.

A long constrained-random run then mixes sparse matches with reads and with changes of enable, mode and select code, at random phases of the slow references. This exposes interactions between disarm and re-arm, and shows whether a code change waits for a reference edge. A cycle-accurate bench model built from the requirements predicts the flags and the pin on every cycle.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  // Pin function codes; the encoding is fixed by the select input.
  typedef enum logic [1:0] {
    PINF_IRQ   = 2'b00,
    PINF_HF    = 2'b01,
    PINF_CENTI = 2'b10,
    PINF_SEC   = 2'b11
  } pin_func_e;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/rtc_alarm_flags.sv
module rtc_alarm_flags #(
  parameter int unsigned NUM_ALARMS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_ALARMS-1:0] match_i,
  input  logic                  stat_rd_i,
  output logic [NUM_ALARMS-1:0] flags_o
);

  logic [NUM_ALARMS-1:0] flags_q, flags_d;

  // A set in the same cycle as a clear wins, so no event is lost.
  always_comb begin
    flags_d = flags_q;
    if (stat_rd_i) flags_d = '0;
    flags_d = flags_d | match_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_chk
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      match_i[i] |=> flags_q[i]);                                  // R2
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd_i && !match_i[i]) |=> !flags_q[i]);                 // R3
  end

endmodule

// File: rtl/rtc_alarm_arm.sv
module rtc_alarm_arm #(
  parameter int unsigned NUM_ALARMS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_ALARMS-1:0] alarm_en_i,
  input  logic                  pulse_mode_i,
  input  logic [NUM_ALARMS-1:0] fire_i,
  output logic [NUM_ALARMS-1:0] armed_o
);

  logic [NUM_ALARMS-1:0] armed_q, armed_d;
  logic [NUM_ALARMS-1:0] en_prev_q;
  logic                  mode_prev_q;
  logic [NUM_ALARMS-1:0] rewrite;

  // A new value on the enable or on the mode bit re-arms; re-arm wins over disarm.
  always_comb begin
    for (int i = 0; i < NUM_ALARMS; i++) begin
      rewrite[i] = (alarm_en_i[i] != en_prev_q[i]) || (pulse_mode_i != mode_prev_q);
      if (rewrite[i])                        armed_d[i] = 1'b1;
      else if (fire_i[i] && !pulse_mode_i)   armed_d[i] = 1'b0;
      else                                   armed_d[i] = armed_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q     <= '1;
      en_prev_q   <= '0;
      mode_prev_q <= 1'b0;
    end else begin
      armed_q     <= armed_d;
      en_prev_q   <= alarm_en_i;
      mode_prev_q <= pulse_mode_i;
    end
  end

  assign armed_o = armed_q;

  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_chk
    AST_SINGLE_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_i[i] && !pulse_mode_i && !rewrite[i]) |=> !armed_q[i]);  // R6
    AST_RECUR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q[i] && pulse_mode_i) |=> armed_q[i]);                  // R7
  end

endmodule

// File: rtl/rtc_pulse_timer.sv
module rtc_pulse_timer
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 655
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tick_i,
  output logic active_o
);

  localparam int unsigned CW = cnt_width(PULSE_TICKS);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // A start reloads (restart, never stacks); otherwise count down on ticks.
  always_comb begin
    cnt_en = start_i || (tick_i && (cnt_q != '0));
    cnt_d  = start_i ? LOAD : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);

  AST_PULSE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_q == LOAD));                                    // R5
  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !tick_i) |=> $stable(cnt_q));                       // R4

endmodule

// File: rtl/rtc_pin_mux.sv
module rtc_pin_mux
  import rtc_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] fsel_i,
  input  logic       ref_hf_i,
  input  logic       ref_centi_i,
  input  logic       ref_sec_i,
  input  logic       pulse_on_i,
  output logic       hf_rise_o,
  output logic       irq_route_o,
  output logic       pin_o
);

  pin_func_e code_q, code_d;
  logic      code_en;
  logic      hf_prev_q;

  always_comb begin
    hf_rise_o = ref_hf_i && !hf_prev_q;
    code_d    = pin_func_e'(fsel_i);
    code_en   = hf_rise_o && (code_d != code_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q    <= PINF_IRQ;
      hf_prev_q <= 1'b0;
    end else begin
      hf_prev_q <= ref_hf_i;
      if (code_en) code_q <= code_d;
    end
  end

  always_comb begin
    unique case (code_q)
      PINF_IRQ:   pin_o = !pulse_on_i;
      PINF_HF:    pin_o = ref_hf_i;
      PINF_CENTI: pin_o = ref_centi_i;
      default:    pin_o = ref_sec_i;
    endcase
  end

  assign irq_route_o = (code_q == PINF_IRQ);

  AST_CODE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !hf_rise_o |=> $stable(code_q));                                 // R9

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq #(
  parameter int unsigned NUM_ALARMS  = 2,
  parameter int unsigned PULSE_TICKS = 655
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_ALARMS-1:0] match_i,
  input  logic [NUM_ALARMS-1:0] alarm_en_i,
  input  logic                  pulse_mode_i,
  input  logic [1:0]            fsel_i,
  input  logic                  stat_rd_i,
  input  logic                  ref_hf_i,
  input  logic                  ref_centi_i,
  input  logic                  ref_sec_i,
  output logic [NUM_ALARMS-1:0] flags_o,
  output logic                  pin_o
);

  logic [1:0]            rst_pipe_q;
  logic                  rst_ln;
  logic [NUM_ALARMS-1:0] armed;
  logic [NUM_ALARMS-1:0] fire;
  logic                  hf_rise;
  logic                  irq_route;
  logic                  pulse_on;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ln = rst_pipe_q[1];

  assign fire = match_i & alarm_en_i & armed & {NUM_ALARMS{irq_route}};

  rtc_alarm_flags #(.NUM_ALARMS(NUM_ALARMS)) u_flags (
    .clk       (clk),
    .rst_n     (rst_ln),
    .match_i   (match_i),
    .stat_rd_i (stat_rd_i),
    .flags_o   (flags_o)
  );

  rtc_alarm_arm #(.NUM_ALARMS(NUM_ALARMS)) u_arm (
    .clk          (clk),
    .rst_n        (rst_ln),
    .alarm_en_i   (alarm_en_i),
    .pulse_mode_i (pulse_mode_i),
    .fire_i       (fire),
    .armed_o      (armed)
  );

  rtc_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_ln),
    .start_i  (|fire),
    .tick_i   (hf_rise),
    .active_o (pulse_on)
  );

  rtc_pin_mux u_mux (
    .clk         (clk),
    .rst_n       (rst_ln),
    .fsel_i      (fsel_i),
    .ref_hf_i    (ref_hf_i),
    .ref_centi_i (ref_centi_i),
    .ref_sec_i   (ref_sec_i),
    .pulse_on_i  (pulse_on),
    .hf_rise_o   (hf_rise),
    .irq_route_o (irq_route),
    .pin_o       (pin_o)
  );

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_ln)
    (((match_i & alarm_en_i) == '0) && !pulse_on) |=> !pulse_on);    // R1
  AST_ROUTED_AWAY: assert property (@(posedge clk) disable iff (!rst_ln)
    (!irq_route && !pulse_on) |=> !pulse_on);                        // R10

endmodule

// File: tb/rtc_alarm_irq_test.sv
`timescale 1ns/1ps
module rtc_alarm_irq_test;

  localparam int P = 655;
  localparam int PULSE_CYC = P * 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] match, en, fsel, flags;
  logic       mode, rd, hf, centi, sec, pin;

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  bit chk_on  = 0;

  // bench model state
  logic [1:0] m_flags, m_armed, m_enp;
  logic       m_modep, m_hfp;
  int         m_cnt;
  logic [1:0] m_code;

  always #2.5 clk = ~clk;

  rtc_alarm_irq uut (
    .clk(clk), .rst_n(rst_n), .match_i(match), .alarm_en_i(en),
    .pulse_mode_i(mode), .fsel_i(fsel), .stat_rd_i(rd),
    .ref_hf_i(hf), .ref_centi_i(centi), .ref_sec_i(sec),
    .flags_o(flags), .pin_o(pin)
  );

  function automatic logic exp_pin_f(logic [1:0] code, int cnt, logic h, logic c, logic s);
    case (code)
      2'b00:   return (cnt == 0);
      2'b01:   return h;
      2'b10:   return c;
      default: return s;
    endcase
  endfunction

  // Cycle model derived from R1..R11.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_flags = '0; m_armed = '1; m_enp = '0; m_modep = 0; m_hfp = 0;
      m_cnt = 0; m_code = 2'b00;
    end else begin
      logic rise;
      logic [1:0] fire;
      rise = hf && !m_hfp;
      for (int i = 0; i < 2; i++)
        fire[i] = match[i] && en[i] && m_armed[i] && (m_code == 2'b00);
      m_flags = (rd ? 2'b00 : m_flags) | match;
      for (int i = 0; i < 2; i++) begin
        if ((en[i] != m_enp[i]) || (mode != m_modep)) m_armed[i] = 1'b1;
        else if (fire[i] && !mode)                    m_armed[i] = 1'b0;
      end
      if (fire != 2'b00)           m_cnt = P;
      else if (rise && m_cnt != 0) m_cnt = m_cnt - 1;
      if (rise && fsel != m_code) m_code = fsel;
      m_enp = en; m_modep = mode; m_hfp = hf;
    end
  end

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // One cycle: compare against the model, then advance the references.
  task automatic tick();
    @(negedge clk);
    cyc++;
    if (chk_on) begin
      check("R2/R3 flags", flags, m_flags);
      check(m_code == 2'b00 ? "R4 pin" : "R8 pin", {1'b0, pin},
            {1'b0, exp_pin_f(m_code, m_cnt, hf, centi, sec)});
    end
    if (cyc % 2 == 0)  hf    = ~hf;
    if (cyc % 16 == 0) centi = ~centi;
    if (cyc % 64 == 0) sec   = ~sec;
  endtask

  task automatic wait_n(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic hit(logic [1:0] m);
    match = m; tick(); match = 2'b00;
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1286));
    rst_n = 0; match = 0; en = 0; mode = 0; fsel = 0; rd = 0;
    hf = 0; centi = 0; sec = 0;
    wait_n(5);
    rst_n = 1;
    wait_n(6);
    chk_on = 1;
    // R11 reset state
    check("R11 flags", flags, 2'b00);
    check("R11 pin", {1'b0, pin}, 2'b01);

    // R1, R2: disabled match latches the flag only
    hit(2'b01); tick();
    check("R2 flag on disabled match", flags, 2'b01);
    check("R1 pin stays high", {1'b0, pin}, 2'b01);

    // R3: read clears; a coincident match wins
    rd = 1; tick(); rd = 0; tick();
    check("R3 clear", flags, 2'b00);
    rd = 1; match = 2'b10; tick(); rd = 0; match = 0; tick();
    check("R3 set beats clear", flags, 2'b10);
    rd = 1; tick(); rd = 0;

    // R4: enabled match gives a timed pulse
    en = 2'b01; wait_n(3);
    hit(2'b01);
    check("R4 pin low", {1'b0, pin}, 2'b00);
    wait_n(PULSE_CYC + 8);
    check("R4 pin released", {1'b0, pin}, 2'b01);

    // R6: single mode disarms, rewriting enable re-arms
    hit(2'b01); tick();
    check("R6 disarmed", {1'b0, pin}, 2'b01);
    en = 2'b00; tick(); en = 2'b01; tick();
    hit(2'b01);
    check("R6 re-armed", {1'b0, pin}, 2'b00);
    wait_n(PULSE_CYC + 8);

    // R7: recurring mode fires every time
    mode = 1; tick();
    hit(2'b01); wait_n(PULSE_CYC + 8);
    check("R7 first released", {1'b0, pin}, 2'b01);
    hit(2'b01);
    check("R7 fires again", {1'b0, pin}, 2'b00);

    // R5: a mid-pulse match restarts the count
    wait_n(1000); hit(2'b01); wait_n(2000);
    check("R5 still low after restart", {1'b0, pin}, 2'b00);
    wait_n(PULSE_CYC);
    check("R5 released", {1'b0, pin}, 2'b01);

    // R10, R8, R9: frequency output blocks the interrupt
    rd = 1; tick(); rd = 0;
    fsel = 2'b01; wait_n(8);
    hit(2'b01); tick();
    check("R10 flag still sets", flags, 2'b01);
    fsel = 2'b00; wait_n(8);
    check("R10 no pulse started", {1'b0, pin}, 2'b01);

    // Random mix, checked every cycle against the model (R1..R10)
    for (int n = 0; n < 20000; n++) begin
      for (int i = 0; i < 2; i++) match[i] = ($urandom % 600) == 0;
      rd = ($urandom % 50) == 0;
      if (($urandom % 1500) == 0) en[$urandom % 2] = ~en[$urandom % 2];
      if (($urandom % 3000) == 0) mode = ~mode;
      if (($urandom % 4000) == 0) fsel = ($urandom % 2) ? 2'($urandom) : 2'b00;
      tick();
    end
    match = 0; rd = 0;
    wait_n(4);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule